// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects 32 external interrupt request lines and presents one request and one vector to a single CPU. Each line has a fixed vector, its line number plus 32, and its priority is fixed as well: a higher vector always wins. The controller tracks pending and in-service lines. A higher-priority line can preempt the one in service. Lower ones wait until software signals end of interrupt.

Software reaches the controller over a simple single-cycle register bus. A local group of registers holds the task priority, the processor priority, the end-of-interrupt strobe and the in-service and pending bitmaps. Each line has a mask bit and a trigger-mode bit. These are reached indirectly: software writes a scrambled line index to a select register, then reads or writes a data window. The CPU takes the offered vector with a one-cycle acknowledge pulse.

Top module: `fixed_vector_intc`

## Requirements
- R1: Line n is always delivered on `cpu_vector` as n + 32, and `cpu_irq` is low when no line is eligible.
- R2: Among pending, unmasked lines, the highest-numbered one is offered.
- R3: A pending line is offered only if its vector is above the highest in-service vector. A higher line preempts the line in service, and a lower line stays pending while a higher one is in service.
- R4: An acknowledge while `cpu_irq` is high clears the offered line's pending bit and sets its in-service bit. An acknowledge while `cpu_irq` is low has no effect.
- R5: A write to the end-of-interrupt register (0x0B0) clears only the highest set in-service bit, whatever the data. After it, the highest remaining eligible pending line is offered.
- R6: Reading 0x110 returns the in-service bitmap with bit n for line n. Reading 0x210 returns the pending bitmap. Reading 0x0A0 returns the processor priority: the larger of the task priority and the highest in-service vector (0 if none). Unmapped addresses read zero.
- R7: The task-priority register at 0x080 holds write-data bits 7:0 and reads its upper bits as zero. A line is offered only if its vector is strictly above the processor priority.
- R8: The select register is at 0x1000 and the data window at 0x1010. The select index for line n is ((n & 7) << 1) | ((n & 0x18) << 2). In the window, bit 16 is the mask (1 = masked) and bit 15 is the trigger mode (1 = level, 0 = edge). All other window bits read zero and ignore writes.
- R9: A select value that is not the index of any line makes window reads return zero and window writes do nothing.
- R10: After reset every line is masked and edge-triggered, no line is pending or in service, the task priority is zero and `cpu_irq` is low.
- R11: An edge line latches pending on a rising input and stays pending after the input falls. A level line's pending bit follows its input, so a line still held high requests again after its end of interrupt.
- R12: A masked line still records pending, visible at 0x210, but is never offered until it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 32 | External request lines, bit n is line n |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during a read |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_vector | output | 8 | Vector of the offered line |
| cpu_ack | input | 1 | CPU acknowledge pulse, takes the offered vector |

## Verification
Some rules are checked by the assertions on every cycle. They check that an offered vector lies in range, that it belongs to an unmasked, pending line with no higher eligible rival, and that it sits above every in-service line. They also check that an acknowledge moves exactly that line into service, and that each end-of-interrupt write retires exactly one in-service bit. Other behaviour only the bench's scenarios show: the scrambled index decode, the rejection of invalid indices, the task-priority gate, the masked-but-pending case, and the difference between edge lines that stay latched and level lines that request again after end of interrupt.

// File: rtl/fixed_vector_intc.sv
module fixed_vector_intc #(
  parameter int VBASE = 32,
  parameter int AW    = 13,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   irq_lines,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          cpu_irq,
  output logic [7:0]    cpu_vector,
  input  logic          cpu_ack
);
  localparam int NL = 32;
  localparam int LW = $clog2(NL);
  localparam logic [AW-1:0] A_TPR = AW'('h080);
  localparam logic [AW-1:0] A_PPR = AW'('h0A0);
  localparam logic [AW-1:0] A_EOI = AW'('h0B0);
  localparam logic [AW-1:0] A_ISR = AW'('h110);
  localparam logic [AW-1:0] A_IRR = AW'('h210);
  localparam logic [AW-1:0] A_SEL = AW'('h1000);
  localparam logic [AW-1:0] A_WIN = AW'('h1010);

  logic [NL-1:0] mask_q, lvl_q, pend_q, isr_q, prev_q;
  logic [NL-1:0] pend_d, isr_d, cand;
  logic [7:0]    tpr_q, ppr, top_vec, best_vec;
  logic [DW-1:0] sel_q;
  logic [LW-1:0] sel_line, top_isr, best;
  logic          sel_ok, isr_any, best_any, take, wr, eoi_wr;

  assign wr       = bus_req & bus_we;
  assign eoi_wr   = wr && (bus_addr == A_EOI);
  assign sel_line = {sel_q[6:5], sel_q[3:1]};
  assign sel_ok   = !sel_q[0] && !sel_q[4] && (sel_q[DW-1:7] == '0);
  assign cand     = pend_q & ~mask_q;

  always_comb begin
    top_isr  = '0;
    isr_any  = 1'b0;
    best     = '0;
    best_any = 1'b0;
    for (int i = 0; i < NL; i++) begin
      if (isr_q[i]) begin
        top_isr = LW'(i);
        isr_any = 1'b1;
      end
      if (cand[i]) begin
        best     = LW'(i);
        best_any = 1'b1;
      end
    end
  end

  assign top_vec    = isr_any ? 8'(top_isr) + 8'(VBASE) : 8'd0;
  assign ppr        = (top_vec > tpr_q) ? top_vec : tpr_q;
  assign best_vec   = 8'(best) + 8'(VBASE);
  assign cpu_irq    = best_any && (best_vec > ppr);
  assign cpu_vector = best_vec;
  assign take       = cpu_ack & cpu_irq;

  always_comb begin
    for (int i = 0; i < NL; i++)
      pend_d[i] = lvl_q[i] ? irq_lines[i] : (pend_q[i] | (irq_lines[i] & ~prev_q[i]));
    if (take) pend_d[best] = 1'b0;
    isr_d = isr_q;
    if (eoi_wr && isr_any) isr_d[top_isr] = 1'b0;
    if (take) isr_d[best] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      lvl_q  <= '0;
      pend_q <= '0;
      isr_q  <= '0;
      prev_q <= '0;
      tpr_q  <= '0;
      sel_q  <= '0;
    end else begin
      prev_q <= irq_lines;
      pend_q <= pend_d;
      isr_q  <= isr_d;
      if (wr && bus_addr == A_TPR) tpr_q <= bus_wdata[7:0];
      if (wr && bus_addr == A_SEL) sel_q <= bus_wdata;
      if (wr && bus_addr == A_WIN && sel_ok) begin
        mask_q[sel_line] <= bus_wdata[16];
        lvl_q[sel_line]  <= bus_wdata[15];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we) begin
      unique case (bus_addr)
        A_TPR:   bus_rdata = DW'(tpr_q);
        A_PPR:   bus_rdata = DW'(ppr);
        A_ISR:   bus_rdata = isr_q;
        A_IRR:   bus_rdata = pend_q;
        A_SEL:   bus_rdata = sel_q;
        A_WIN:   if (sel_ok) bus_rdata = DW'({mask_q[sel_line], lvl_q[sel_line]}) << 15;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fixed_vector_intc_chk.sv
module fixed_vector_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_irq,
  input logic [7:0]  cpu_vector,
  input logic        cpu_ack,
  input logic [31:0] isr,
  input logic [31:0] pend,
  input logic [31:0] mask,
  input logic        eoi
);
  p_vec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (cpu_vector >= 8'd32 && cpu_vector < 8'd64));

  p_highest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (((pend & ~mask) >> cpu_vector[4:0]) == 32'd1));

  p_preempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((isr >> cpu_vector[4:0]) == 32'd0));

  p_ack_isr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cpu_ack) |=> isr[$past(cpu_vector[4:0])]);

  p_ack_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cpu_ack) |=> !pend[$past(cpu_vector[4:0])]);

  p_eoi_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr != 32'd0 && !(cpu_irq && cpu_ack)) |=>
      ($countones(isr) == $countones($past(isr)) - 1));

  p_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> !mask[cpu_vector[4:0]]);
endmodule

bind fixed_vector_intc fixed_vector_intc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .cpu_vector(cpu_vector),
  .cpu_ack(cpu_ack), .isr(isr_q), .pend(pend_q), .mask(mask_q), .eoi(eoi_wr)
);

// File: tb/test_fixed_vector_intc.sv
module test_fixed_vector_intc;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0, cpu_ack = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cpu_irq;
  logic [7:0]  cpu_vector;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fixed_vector_intc i_fixed_vector_intc (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .cpu_vector(cpu_vector),
    .cpu_ack(cpu_ack));

  localparam logic [12:0] SEL = 13'h1000, WIN = 13'h1010, TPR = 13'h080,
                          PPR = 13'h0A0, EOI = 13'h0B0, ISR = 13'h110, IRR = 13'h210;
  // {we, addr, wdata, expected read}
  localparam int NT = 19;
  localparam logic [77:0] TBL [NT] = '{
    {1'b0, ISR,  32'h0, 32'h0},           // R10 nothing in service
    {1'b0, IRR,  32'h0, 32'h0},           // R10 nothing pending
    {1'b0, TPR,  32'h0, 32'h0},           // R10 task priority zero
    {1'b1, SEL,  32'h66, 32'h0},          // R8 line 27
    {1'b0, WIN,  32'h0, 32'h0001_0000},   // R10 masked, edge
    {1'b1, SEL,  32'h0A, 32'h0},          // R8 line 5
    {1'b1, WIN,  32'hFFFF_FFFF, 32'h0},
    {1'b0, WIN,  32'h0, 32'h0001_8000},   // R8 unsupported bits zero
    {1'b1, WIN,  32'h0000_8000, 32'h0},
    {1'b0, WIN,  32'h0, 32'h0000_8000},   // R8 unmasked level
    {1'b1, SEL,  32'h01, 32'h0},          // R9 invalid index
    {1'b0, WIN,  32'h0, 32'h0},           // R9 reads zero
    {1'b1, WIN,  32'h0, 32'h0},           // R9 write ignored
    {1'b1, SEL,  32'h00, 32'h0},
    {1'b0, WIN,  32'h0, 32'h0001_0000},   // R9 line 0 untouched
    {1'b1, TPR,  32'hFFFF_FF35, 32'h0},
    {1'b0, TPR,  32'h0, 32'h35},          // R7 upper bits zero
    {1'b0, PPR,  32'h0, 32'h35},          // R6 processor priority
    {1'b0, 13'h300, 32'h0, 32'h0}         // R6 unmapped reads zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [12:0] a, input logic [31:0] d,
                    output logic [31:0] q);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #5 q = bus_rdata;
    @(posedge clk);
    #1 bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    logic [31:0] q;
    op(1'b1, a, d, q);
  endtask

  task automatic rd(input string req, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] q;
    op(1'b0, a, 32'h0, q);
    chk(req, q, exp);
  endtask

  function automatic logic [31:0] idx(input int n);
    return 32'(((n & 7) << 1) | ((n & 24) << 2));
  endfunction

  task automatic cfg(input int n, input logic m, input logic lv);
    wr(SEL, idx(n));
    wr(WIN, {15'b0, m, lv, 15'b0});
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq_lines[n] = 1'b1;
    @(negedge clk); irq_lines[n] = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic irq_is(input string req, input logic on, input int vec);
    @(negedge clk);
    chk(req, {23'b0, cpu_irq, on ? cpu_vector : 8'h0}, {23'b0, on, on ? 8'(vec) : 8'h0});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_is("R10", 1'b0, 0);
    for (int i = 0; i < NT; i++) begin
      op(TBL[i][77], TBL[i][76:64], TBL[i][63:32], q);
      if (!TBL[i][77]) chk("R6/R7/R8/R9/R10 table", q, TBL[i][31:0]);
    end
    wr(TPR, 32'h0);

    cfg(3, 1'b0, 1'b0);
    cfg(10, 1'b0, 1'b0);
    cfg(20, 1'b0, 1'b0);
    cfg(12, 1'b0, 1'b0);
    pulse(3);
    irq_is("R1 R11 edge latched", 1'b1, 35);
    rd("R6 pending map", IRR, 32'h8);
    pulse(10);
    irq_is("R2 highest wins", 1'b1, 42);
    ack();
    irq_is("R3 lower held", 1'b0, 0);
    rd("R4 in service", ISR, 32'h400);
    rd("R4 pending left", IRR, 32'h8);
    pulse(20);
    irq_is("R3 preempt", 1'b1, 52);
    ack();
    rd("R4 nested", ISR, 32'h0010_0400);
    rd("R6 ppr", PPR, 32'd52);
    wr(EOI, 32'hDEAD_BEEF);
    rd("R5 top cleared only", ISR, 32'h400);
    irq_is("R5 still held", 1'b0, 0);
    wr(EOI, 32'h0);
    irq_is("R5 next delivered", 1'b1, 35);
    ack();
    wr(EOI, 32'h0);
    rd("R5 all retired", ISR, 32'h0);
    irq_is("R1 idle", 1'b0, 0);
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    rd("R4 stray ack", ISR, 32'h0);

    wr(TPR, 32'h30);
    pulse(12);
    irq_is("R7 blocked by tpr", 1'b0, 0);
    rd("R6 ppr from tpr", PPR, 32'h30);
    wr(TPR, 32'h2B);
    irq_is("R7 above tpr", 1'b1, 44);
    ack();
    wr(EOI, 32'h0);
    wr(TPR, 32'h0);

    pulse(27);
    irq_is("R12 masked", 1'b0, 0);
    rd("R12 still pending", IRR, 32'h0800_0000);
    cfg(27, 1'b0, 1'b0);
    irq_is("R12 unmasked", 1'b1, 59);
    ack();
    wr(EOI, 32'h0);

    @(negedge clk); irq_lines[5] = 1'b1;
    irq_is("R11 level", 1'b1, 37);
    ack();
    @(negedge clk);
    irq_is("R11 level in service", 1'b0, 0);
    wr(EOI, 32'h0);
    irq_is("R11 re-request", 1'b1, 37);
    ack();
    irq_lines[5] = 1'b0;
    wr(EOI, 32'h0);
    irq_is("R11 level dropped", 1'b0, 0);
    rd("R11 level pending clear", IRR, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule